// File: doc/BRIEF.md
# Event/Tick Counter with Sampled Falling-Edge Input

This block is a 16-bit counting register with two sources of advance, picked by a mode input. In tick mode the register steps by one on every core clock cycle, so its rate equals the clock frequency. In event mode it steps only when an external pin, which belongs to this instance alone, goes from high to low. A two-flop synchronizer resamples the pin once per clock. A falling transition is recognised when one sample reads high and the sample one clock later reads low. Because of this, event counting tops out at half the clock rate.

Software or a neighbouring block can write a start value through a parallel load port. That value is also kept as the reload value. When the register steps past all-ones, it takes the reload value and raises an overflow pulse. A run input freezes the count. Falling edges that occur while the count is frozen are discarded. They are not queued for later.

Top module: `evtick_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` becomes 0 and `ovf` becomes 0. The stored reload value and the pin history also clear to 0.
- R2: In tick mode (`mode` = 0), with `run` = 1 and `load_en` = 0, `count` rises by exactly one at every rising clock edge.
- R3: In event mode (`mode` = 1), `count` rises by one only for a falling pin transition. If `ext_pin` is sampled high at edge k-1 and low at edge k, `count` steps at edge k+2, which is two synchronizer stages later. At every other edge it does not change.
- R4: A pin that toggles on every clock produces one step per two clocks, which is the maximum event rate. A pin held at a constant level produces no steps.
- R5: With `run` = 0 and `load_en` = 0, `count` holds its value. A falling transition whose detection edge falls while `run` = 0 is never counted, even after `run` returns to 1.
- R6: With `load_en` = 1, the next edge writes `load_val` into `count` and into the reload value. This happens whatever the states of `run` and `mode` are, and it overrides any step in that same cycle.
- R7: A step taken from `count` = 16'hFFFF loads the reload value instead of 0. `ovf` is 1 in the cycle right after that edge and only then.
- R8: A change of `mode` applies at the very next edge. The pin sample history keeps updating in both modes, so a falling transition sampled while in tick mode is counted if event mode is active at its detection edge.
- R9: `ovf` is never 1 unless the previous edge carried out a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Count enable; 0 freezes the register |
| mode | input | 1 | 0 = tick mode (every clock), 1 = event mode (pin falling edges) |
| ext_pin | input | 1 | Asynchronous external event input |
| load_en | input | 1 | Parallel load strobe |
| load_val | input | 16 | Value written to the count and the reload value |
| count | output | 16 | Current count |
| ovf | output | 1 | One-cycle pulse after a wrap |

## Verification
A reference model in the bench keeps the pin history as a queue and is compared with the outputs on every clock. Tick mode is run with no other stimulus, which isolates the per-clock step. Event mode is driven four ways, and each separates a different part of the behaviour:
- A pin toggling every clock shows the half-rate limit.
- A slow square wave exposes the two-stage delay.
- A held pin confirms that levels are ignored.
- A random pin mixes all of these.

Further sequences cover the remaining rules:
- Toggling the pin with run low confirms that dropped edges stay dropped.
- Switching mode while a fall is in flight checks that the history is kept.
- Loads near all-ones exercise wrap-to-reload and the overflow pulse, with the load issued against a pending step to confirm its priority.

// File: rtl/tc_pkg.sv
package tc_pkg;
  parameter int unsigned TC_W = 16;
  parameter int unsigned SYNC_STAGES = 2;

  typedef logic [TC_W-1:0] cnt_t;

  typedef enum logic {
    MODE_TICK  = 1'b0,
    MODE_EVENT = 1'b1
  } cnt_mode_e;

  // True when the next step must wrap.
  function automatic logic at_top(input cnt_t v);
    return (v == {TC_W{1'b1}});
  endfunction

  // Value after one step: wrap to the reload value past all-ones.
  function automatic cnt_t step_value(input cnt_t v, input cnt_t reload);
    return at_top(v) ? reload : cnt_t'(v + cnt_t'(1));
  endfunction

  // High-then-low across two consecutive samples.
  function automatic logic is_fall(input logic older, input logic newer);
    return older & ~newer;
  endfunction
endpackage

// File: rtl/tc_sync.sv
module tc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/tc_fall_detect.sv
module tc_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  output logic fall
);
  import tc_pkg::*;

  logic prev_sample;

  // History runs in every mode and run state so that it survives mode changes.
  always_ff @(posedge clk) begin
    if (rst) prev_sample <= 1'b0;
    else     prev_sample <= sample;
  end

  assign fall = is_fall(prev_sample, sample);

  // R4: two falls can never be seen on back-to-back cycles
  p_fall_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          load_en,
  input  tc_pkg::cnt_t  load_val,
  output tc_pkg::cnt_t  count,
  output logic          ovf,
  output logic          wrap_evt
);
  import tc_pkg::*;

  cnt_t value_q;
  cnt_t reload_q;
  logic ovf_q;

  assign wrap_evt = step & ~load_en & at_top(value_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q  <= '0;
      reload_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      ovf_q <= wrap_evt;
      if (load_en) begin
        value_q  <= load_val;
        reload_q <= load_val;
      end else if (step) begin
        value_q <= step_value(value_q, reload_q);
      end
    end
  end

  assign count = value_q;
  assign ovf   = ovf_q;

  // R6: load wins over a step
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (count == $past(load_val)));
  // R7: a wrap is followed by the overflow pulse
  p_wrap_flag_r7: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> ovf);
  // R9: no overflow pulse without a wrap
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    !wrap_evt |=> !ovf);
endmodule

// File: rtl/evtick_counter.sv
module evtick_counter (
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic        mode,
  input  logic        ext_pin,
  input  logic        load_en,
  input  logic [15:0] load_val,
  output logic [15:0] count,
  output logic        ovf
);
  import tc_pkg::*;

  logic      pin_sync;
  logic      fall_evt;
  logic      step_evt;
  logic      wrap_evt;
  cnt_mode_e mode_sel;

  assign mode_sel = cnt_mode_e'(mode);

  tc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (ext_pin),
    .q_sync  (pin_sync)
  );

  tc_fall_detect u_edge (
    .clk    (clk),
    .rst    (rst),
    .sample (pin_sync),
    .fall   (fall_evt)
  );

  always_comb begin
    step_evt = 1'b0;
    if (run) begin
      case (mode_sel)
        MODE_TICK:  step_evt = 1'b1;
        MODE_EVENT: step_evt = fall_evt;
        default:    step_evt = 1'b0;
      endcase
    end
  end

  tc_count_core u_core (
    .clk      (clk),
    .rst      (rst),
    .step     (step_evt),
    .load_en  (load_en),
    .load_val (load_val),
    .count    (count),
    .ovf      (ovf),
    .wrap_evt (wrap_evt)
  );

  // R1: reset clears the visible state
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count == '0 && !ovf));
  // R2: tick mode steps on every clock below the top
  p_tick_step_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !mode && !load_en && count != 16'hFFFF) |=> (count == $past(count) + 16'd1));
  // R5: frozen when run is low
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_en) |=> $stable(count));
  // R3: in event mode, no step without a detected fall
  p_event_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (mode && !fall_evt && !load_en) |=> $stable(count));
endmodule

// File: tb/sim_evtick_counter.sv
`timescale 1ns/1ps
module sim_evtick_counter;
  logic        clk = 1'b0;
  logic        rst, run, mode, ext_pin, load_en;
  logic [15:0] load_val;
  logic [15:0] count;
  logic        ovf;

  always #4 clk = ~clk;  // 125 MHz

  evtick_counter u0 (
    .clk(clk), .rst(rst), .run(run), .mode(mode), .ext_pin(ext_pin),
    .load_en(load_en), .load_val(load_val), .count(count), .ovf(ovf)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string tag     = "R1";
  bit    done    = 0;

  // Reference model: pin samples kept in a queue, oldest first.
  int m_cnt, m_rel, m_ovf;
  int pin_q[$];

  always @(posedge clk) begin
    int older, newer, stepping;
    if (rst) begin
      m_cnt = 0; m_rel = 0; m_ovf = 0;
      pin_q = '{0, 0, 0};
    end else begin
      older = pin_q[pin_q.size()-3];   // sampled three edges back
      newer = pin_q[pin_q.size()-2];   // sampled two edges back
      stepping = run && (mode ? (older == 1 && newer == 0) : 1);
      m_ovf = 0;
      if (load_en) begin
        m_cnt = load_val; m_rel = load_val;
      end else if (stepping) begin
        if (m_cnt == 65535) begin m_cnt = m_rel; m_ovf = 1; end
        else m_cnt = m_cnt + 1;
      end
      pin_q.push_back(int'(ext_pin));
      void'(pin_q.pop_front());
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (count !== m_cnt[15:0]) begin
      n_fail++;
      $display("FAIL %s count got %h expected %h", tag, count, m_cnt[15:0]);
    end
    n_tests++;
    if (ovf !== m_ovf[0]) begin
      n_fail++;
      $display("FAIL %s ovf got %b expected %b", tag, ovf, m_ovf[0]);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_load(input logic [15:0] v);
    load_en = 1; load_val = v; cyc(); load_en = 0;
  endtask

  initial begin
    rst = 1; run = 0; mode = 0; ext_pin = 0; load_en = 0; load_val = 0;
    tag = "R1"; cycles(3);
    rst = 0;

    // R2: tick mode
    tag = "R2"; run = 1; mode = 0; cycles(20);

    // R6: load against a pending tick step, then R7 wrap to the reload value
    tag = "R6"; do_load(16'hFFF0); cycles(4);
    tag = "R7"; cycles(20);
    tag = "R6"; run = 0; mode = 1; do_load(16'h1234); run = 1; cycles(3);

    // R3: slow square wave in event mode
    tag = "R3"; mode = 1;
    for (int i = 0; i < 8; i++) begin
      ext_pin = 1; cycles(5); ext_pin = 0; cycles(5);
    end

    // R4: maximum rate toggling, then held levels
    tag = "R4";
    for (int i = 0; i < 30; i++) begin ext_pin = ~ext_pin; cyc(); end
    ext_pin = 1; cycles(12); ext_pin = 0; cycles(12);

    // R5: edges while frozen are dropped
    tag = "R5"; run = 0;
    for (int i = 0; i < 16; i++) begin ext_pin = ~ext_pin; cyc(); end
    ext_pin = 0; cycles(4); run = 1; cycles(6);

    // R8: fall sampled in tick mode, detection edge in event mode
    tag = "R8";
    for (int k = 0; k < 4; k++) begin
      mode = 0; ext_pin = 1; cycles(3);
      ext_pin = 0; cycles(k);
      mode = 1; cycles(5);
    end

    // R7: event-mode wrap with a reload near the top
    tag = "R7"; do_load(16'hFFFE);
    for (int i = 0; i < 20; i++) begin ext_pin = ~ext_pin; cyc(); end
    mode = 0; do_load(16'hFFFF); cycles(5);

    // R9: random mix of everything
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      ext_pin  = 1'($urandom);
      mode     = ($urandom % 8) == 0 ? ~mode : mode;
      run      = ($urandom % 6) != 0;
      load_en  = ($urandom % 40) == 0;
      load_val = ($urandom % 2) ? 16'hFFF8 : 16'($urandom);
      cyc();
    end
    load_en = 0;

    // R1: reset again from a busy state
    tag = "R1"; rst = 1; cycles(2); rst = 0; run = 0; cycles(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule